// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block is the core of an eight-line, fixed-priority interrupt controller. Request lines latch into a pending set on their rising edges, and a line that drops again is forgotten. The block raises `irq_out` whenever some pending line outranks every level that is already being serviced. Line 0 has the highest rank. The processor answers with active-low acknowledge pulses on `ack_n`, and the block returns a byte sequence for them on `bus_out`, qualified by `bus_drive`.

There are two sequence formats, chosen by `cfg_three`.
- **Long format:** three pulses. They return a subroutine-call opcode, then the low byte of a service address, then its high byte.
- **Short format:** two pulses. The first pulse returns nothing and the bus stays undriven. The second returns an 8-bit vector pointer.

The serviced level is chosen on the falling edge of the second pulse in the long format, or of the first pulse in the short format. If no line qualifies at that moment, the block returns the vector of the lowest-ranked level. A serviced level is released in one of two ways: on the end of the last pulse when `cfg_auto` is set, or by an `eoi` strobe.

`ack_n` is sampled on the system clock. The byte interface has no back-pressure. Each byte is presented for exactly as long as the processor holds the acknowledge pulse low, so the pulse itself is the handshake. Configuration inputs may change only while no sequence is in progress.

Top module: `intack_vec_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, the pending set and the in-service set are empty. In that state `irq_out`, `bus_drive` and `bus_out` are all 0.
- R2: A 0-to-1 transition on `irq_lines[i]` makes line i pending, and a 0 on that line removes it. `irq_out` is 1 exactly when some pending line has a lower index than every in-service level.
- R3: In the long format (`cfg_three`=1), the first pulse returns 8'hCD and the third pulse returns `cfg_hi`.
- R4: The second long-format pulse returns a low address byte built from the serviced level L. With `cfg_gap8`=0 the byte is {cfg_lo[2:0], L[2:0], 2'b00}. With `cfg_gap8`=1 it is {cfg_lo[2:1], L[2:0], 3'b000}.
- R5: In the long format, the falling edge of pulse two marks level L in service, and the rising edge of pulse two clears L from the pending set. A line that stays high does not become pending again.
- R6: In the short format (`cfg_three`=0), pulse one leaves `bus_drive` at 0. It also marks L in service and clears L from the pending set. Pulse two returns {cfg_ptr[4:0], L[2:0]}.
- R7: With `cfg_auto`=1, level L leaves service at the rising edge of the last pulse of its sequence. With `cfg_auto`=0, it stays in service.
- R8: A one-cycle `eoi` strobe removes only the lowest-index level in service.
- R9: If no line qualifies when the level is chosen, L is taken as 7 for the returned bytes and no level enters service.
- R10: When several lines qualify, the lowest index is served.
- R11: `bus_drive` and `bus_out` change in the cycle after the clock edge that first sees `ack_n` low. They return to 0 in the cycle after the edge that first sees `ack_n` high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 8 | Request lines, index 0 highest rank |
| ack_n | input | 1 | Active-low acknowledge pulse from the processor |
| eoi | input | 1 | One-cycle end-of-service strobe |
| cfg_three | input | 1 | 1 = long (three-pulse) format, 0 = short (two-pulse) format |
| cfg_auto | input | 1 | Release the in-service level automatically at the last pulse |
| cfg_gap8 | input | 1 | Service address spacing: 0 = 4 bytes, 1 = 8 bytes |
| cfg_lo | input | 3 | Upper bits of the low address byte |
| cfg_hi | input | 8 | High address byte |
| cfg_ptr | input | 5 | Upper bits of the short-format pointer |
| irq_out | output | 1 | Interrupt request to the processor |
| bus_out | output | 8 | Byte returned during an acknowledge pulse |
| bus_drive | output | 1 | Bus output enable |

## Verification
The bench builds the block with its defaults: eight lines, so three-bit level numbers. At this size every index can be reached, including the lowest-ranked fallback level 7 and the packing of that level into both address spacings. Both formats are driven with automatic release on and off. Levels are nested so that an `eoi` must pick the right one of two in-service levels, and a request is withdrawn just before acknowledgement in each format.

// File: rtl/ivs_pkg.sv
package ivs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CALL_OPCODE = 8'hCD;
  typedef enum logic [1:0] {
    SLOT_FIRST  = 2'd0,
    SLOT_SECOND = 2'd1,
    SLOT_THIRD  = 2'd2
  } slot_e;
endpackage

// File: rtl/ivs_prio.sv
module ivs_prio #(
  parameter int unsigned LINES = 8,
  localparam int unsigned LW = $clog2(LINES)
) (
  input  logic [LINES-1:0] pend,
  input  logic [LINES-1:0] svc,
  output logic             hit,
  output logic [LW-1:0]    hit_lvl,
  output logic [LINES-1:0] svc_top
);
  logic blocked;
  logic found;

  // lowest index pending line that sits above every in-service level
  always_comb begin
    hit     = 1'b0;
    hit_lvl = '0;
    blocked = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (!blocked && !hit) begin
        if (svc[i]) blocked = 1'b1;
        else if (pend[i]) begin
          hit     = 1'b1;
          hit_lvl = LW'(i);
        end
      end
    end
  end

  // lowest index in-service level, one-hot
  always_comb begin
    svc_top = '0;
    found   = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (svc[i] && !found) begin
        svc_top[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ivs_vecgen.sv
module ivs_vecgen
  import ivs_pkg::*;
#(
  parameter int unsigned LW = 3,
  localparam int unsigned PTR_W = BYTE_W - LW,
  localparam int unsigned LO_W  = BYTE_W - LW - 2
) (
  input  logic              three,
  input  logic              gap8,
  input  logic [1:0]        slot,
  input  logic [LW-1:0]     lvl,
  input  logic [LO_W-1:0]   lo_cfg,
  input  logic [BYTE_W-1:0] hi_cfg,
  input  logic [PTR_W-1:0]  ptr_base,
  output logic [BYTE_W-1:0] byte_o,
  output logic              drive_o
);
  logic [BYTE_W-1:0] low_byte;

  always_comb begin
    if (gap8) low_byte = {lo_cfg[LO_W-1:1], lvl, 3'b000};
    else      low_byte = {lo_cfg, lvl, 2'b00};
  end

  always_comb begin
    byte_o  = '0;
    drive_o = 1'b0;
    if (three) begin
      case (slot)
        SLOT_FIRST:  begin byte_o = CALL_OPCODE; drive_o = 1'b1; end
        SLOT_SECOND: begin byte_o = low_byte;    drive_o = 1'b1; end
        SLOT_THIRD:  begin byte_o = hi_cfg;      drive_o = 1'b1; end
        default:     begin byte_o = '0;          drive_o = 1'b0; end
      endcase
    end else if (slot == SLOT_SECOND) begin
      byte_o  = {ptr_base, lvl};
      drive_o = 1'b1;
    end
  end
endmodule

// File: rtl/ivs_ackfsm.sv
module ivs_ackfsm
  import ivs_pkg::*;
#(
  parameter int unsigned LW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_n,
  input  logic              three,
  input  logic              auto_en,
  input  logic              hit,
  input  logic [LW-1:0]     hit_lvl,
  input  logic [BYTE_W-1:0] vec_byte,
  input  logic              vec_drive,
  output logic [1:0]        slot,
  output logic [LW-1:0]     gen_lvl,
  output logic              set_ev,
  output logic [LW-1:0]     set_lvl,
  output logic              pclr_ev,
  output logic [LW-1:0]     pclr_lvl,
  output logic              aclr_ev,
  output logic [LW-1:0]     aclr_lvl,
  output logic              drv_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam logic [LW-1:0] FALLBACK = '1;

  logic          ack_q;
  logic [1:0]    cnt;
  logic [LW-1:0] lvl_q;
  logic          spur_q;
  logic          fall_ev, rise_ev, cap_ev;
  logic [1:0]    last_slot, cap_slot;

  assign fall_ev   = ack_q & ~ack_n;
  assign rise_ev   = ~ack_q & ack_n;
  assign last_slot = three ? SLOT_THIRD : SLOT_SECOND;
  assign cap_slot  = three ? SLOT_SECOND : SLOT_FIRST;
  assign cap_ev    = fall_ev && (cnt == cap_slot);
  assign slot      = cnt;
  assign gen_lvl   = cap_ev ? (hit ? hit_lvl : FALLBACK) : lvl_q;

  assign set_ev  = cap_ev && hit;
  assign set_lvl = hit_lvl;

  always_comb begin
    if (three) begin
      pclr_ev  = rise_ev && (cnt == SLOT_SECOND) && !spur_q;
      pclr_lvl = lvl_q;
    end else begin
      pclr_ev  = cap_ev && hit;
      pclr_lvl = hit_lvl;
    end
  end

  assign aclr_ev  = rise_ev && (cnt == last_slot) && auto_en && !spur_q;
  assign aclr_lvl = lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q  <= 1'b1;
      cnt    <= '0;
      lvl_q  <= '0;
      spur_q <= 1'b0;
      drv_o  <= 1'b0;
      data_o <= '0;
    end else begin
      ack_q <= ack_n;
      if (rise_ev) cnt <= (cnt >= last_slot) ? 2'd0 : cnt + 2'd1;
      if (cap_ev) begin
        lvl_q  <= gen_lvl;
        spur_q <= !hit;
      end
      if (fall_ev) begin
        drv_o  <= vec_drive;
        data_o <= vec_drive ? vec_byte : '0;
      end else if (rise_ev) begin
        drv_o  <= 1'b0;
        data_o <= '0;
      end
    end
  end

  assert_drive_after_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    drv_o |-> !$past(ack_n));

  assert_short_first_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev && !three && cnt == 2'd0) |=> !drv_o);
endmodule

// File: rtl/intack_vec_seq.sv
module intack_vec_seq
  import ivs_pkg::*;
#(
  parameter int unsigned LINES = 8,
  localparam int unsigned LW    = $clog2(LINES),
  localparam int unsigned LO_W  = BYTE_W - LW - 2,
  localparam int unsigned PTR_W = BYTE_W - LW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_lines,
  input  logic              ack_n,
  input  logic              eoi,
  input  logic              cfg_three,
  input  logic              cfg_auto,
  input  logic              cfg_gap8,
  input  logic [LO_W-1:0]   cfg_lo,
  input  logic [BYTE_W-1:0] cfg_hi,
  input  logic [PTR_W-1:0]  cfg_ptr,
  output logic              irq_out,
  output logic [BYTE_W-1:0] bus_out,
  output logic              bus_drive
);
  logic [LINES-1:0]  line_q, pend, svc, svc_top;
  logic [LINES-1:0]  set_vec, pclr_vec, aclr_vec, eoi_vec;
  logic              hit;
  logic [LW-1:0]     hit_lvl, gen_lvl, set_lvl, pclr_lvl, aclr_lvl;
  logic              set_ev, pclr_ev, aclr_ev;
  logic [1:0]        slot;
  logic [BYTE_W-1:0] vec_byte;
  logic              vec_drive;

  ivs_prio #(.LINES(LINES)) u_prio (
    .pend(pend), .svc(svc), .hit(hit), .hit_lvl(hit_lvl), .svc_top(svc_top)
  );

  ivs_vecgen #(.LW(LW)) u_vec (
    .three(cfg_three), .gap8(cfg_gap8), .slot(slot), .lvl(gen_lvl),
    .lo_cfg(cfg_lo), .hi_cfg(cfg_hi), .ptr_base(cfg_ptr),
    .byte_o(vec_byte), .drive_o(vec_drive)
  );

  ivs_ackfsm #(.LW(LW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .three(cfg_three),
    .auto_en(cfg_auto), .hit(hit), .hit_lvl(hit_lvl),
    .vec_byte(vec_byte), .vec_drive(vec_drive), .slot(slot),
    .gen_lvl(gen_lvl), .set_ev(set_ev), .set_lvl(set_lvl),
    .pclr_ev(pclr_ev), .pclr_lvl(pclr_lvl), .aclr_ev(aclr_ev),
    .aclr_lvl(aclr_lvl), .drv_o(bus_drive), .data_o(bus_out)
  );

  assign set_vec  = set_ev  ? (LINES'(1) << set_lvl)  : '0;
  assign pclr_vec = pclr_ev ? (LINES'(1) << pclr_lvl) : '0;
  assign aclr_vec = aclr_ev ? (LINES'(1) << aclr_lvl) : '0;
  assign eoi_vec  = eoi ? svc_top : '0;
  assign irq_out  = hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      pend   <= '0;
      svc    <= '0;
    end else begin
      line_q <= irq_lines;
      pend   <= (pend | (irq_lines & ~line_q)) & irq_lines & ~pclr_vec;
      svc    <= (svc | set_vec) & ~aclr_vec & ~eoi_vec;
    end
  end

  assert_set_was_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |-> ((set_vec & pend) != '0));

  assert_eoi_drops_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && svc != '0 && set_vec == '0 && aclr_vec == '0)
      |=> ($countones(svc) + 1 == $past($countones(svc))));
endmodule

// File: tb/sim_intack_vec_seq.sv
`timescale 1ns/1ps
module sim_intack_vec_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lines = '0;
  logic       ack_n = 1'b1, eoi = 1'b0;
  logic       three = 1'b1, autoc = 1'b0, gap8 = 1'b0;
  logic [2:0] lo = '0;
  logic [7:0] hi = '0;
  logic [4:0] ptr = '0;
  logic       irq_out, bus_drive;
  logic [7:0] bus_out;

  int total = 0, bad = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  intack_vec_seq u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .ack_n(ack_n), .eoi(eoi),
    .cfg_three(three), .cfg_auto(autoc), .cfg_gap8(gap8), .cfg_lo(lo),
    .cfg_hi(hi), .cfg_ptr(ptr), .irq_out(irq_out), .bus_out(bus_out),
    .bus_drive(bus_drive)
  );

  // behavioural reference
  logic [7:0] mp = '0, ms = '0, mlq = '0, np, ns;
  bit   m_ackq = 1'b1, m_spur = 1'b0, m_drv = 1'b0;
  int   m_cnt = 0, m_lvl = 0, m_data = 0;
  int   e, ts, lastp, capp, g;
  bit   fall, rise, cap;

  function automatic int eligible(logic [7:0] p, logic [7:0] s);
    for (int i = 0; i < 8; i++) begin
      if (s[i]) return -1;
      if (p[i]) return i;
    end
    return -1;
  endfunction

  function automatic int low_byte(int lvl);
    if (gap8) return {lo[2:1], 3'(lvl), 3'b000};
    return {lo, 3'(lvl), 2'b00};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mp = '0; ms = '0; mlq = '0; m_ackq = 1; m_spur = 0; m_drv = 0;
      m_cnt = 0; m_lvl = 0; m_data = 0;
    end else begin
      e = eligible(mp, ms);
      ts = -1;
      for (int i = 7; i >= 0; i--) if (ms[i]) ts = i;
      lastp = three ? 2 : 1;
      capp  = three ? 1 : 0;
      fall  = m_ackq && !ack_n;
      rise  = !m_ackq && ack_n;
      cap   = fall && (m_cnt == capp);
      g     = cap ? ((e >= 0) ? e : 7) : m_lvl;
      for (int i = 0; i < 8; i++) np[i] = (mp[i] || (lines[i] && !mlq[i])) && lines[i];
      if (three && rise && m_cnt == 1 && !m_spur) np[m_lvl] = 0;
      if (!three && cap && e >= 0) np[e] = 0;
      ns = ms;
      if (cap && e >= 0) ns[e] = 1;
      if (rise && m_cnt == lastp && autoc && !m_spur) ns[m_lvl] = 0;
      if (eoi && ts >= 0) ns[ts] = 0;
      if (fall) begin
        if (three) begin
          m_drv = (m_cnt <= 2);
          m_data = (m_cnt == 0) ? 8'hCD : (m_cnt == 1) ? low_byte(g) : (m_cnt == 2) ? int'(hi) : 0;
        end else begin
          m_drv = (m_cnt == 1);
          m_data = (m_cnt == 1) ? {ptr, 3'(g)} : 0;
        end
      end else if (rise) begin
        m_drv = 0; m_data = 0;
      end
      if (rise) m_cnt = (m_cnt >= lastp) ? 0 : m_cnt + 1;
      if (cap) begin m_lvl = g; m_spur = (e < 0); end
      m_ackq = ack_n; mlq = lines; mp = np; ms = ns;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    total++;
    if (irq_out !== (eligible(mp, ms) >= 0) || bus_drive !== m_drv || bus_out !== 8'(m_data)) begin
      bad++;
      $display("FAIL %s model: irq=%0b drv=%0b bus=%h expected irq=%0b drv=%0b bus=%h",
               cur_tag, irq_out, bus_drive, bus_out, (eligible(mp, ms) >= 0), m_drv, 8'(m_data));
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // one acknowledge pulse: low for two cycles, high for two
  task automatic pulse(output logic [7:0] d, output logic dv);
    @(negedge clk) ack_n = 1'b0;
    @(negedge clk) begin d = bus_out; dv = bus_drive; end
    @(negedge clk) ack_n = 1'b1;
    @(negedge clk) chk("R11 release", {7'd0, bus_drive}, 8'd0);
    @(negedge clk);
  endtask

  task automatic end_cmd;
    @(negedge clk) eoi = 1'b1;
    @(negedge clk) eoi = 1'b0;
  endtask

  logic [7:0] d;
  logic dv;

  initial begin
    cyc(3);
    chk("R1 irq", {7'd0, irq_out}, 8'd0);
    chk("R1 drive", {7'd0, bus_drive}, 8'd0);
    chk("R1 bus", bus_out, 8'h00);
    @(negedge clk) rst_n = 1'b1;

    // long format, spacing 4
    cur_tag = "R2"; three = 1; gap8 = 0; lo = 3'b101; hi = 8'h9A; autoc = 0;
    @(negedge clk) lines[3] = 1'b1;
    @(negedge clk) chk("R2 irq raised", {7'd0, irq_out}, 8'd1);
    cur_tag = "R3";
    pulse(d, dv); chk("R3 opcode", d, 8'hCD); chk("R11 drive", {7'd0, dv}, 8'd1);
    cur_tag = "R4";
    pulse(d, dv); chk("R4 low gap4", d, 8'hAC);
    cur_tag = "R3";
    pulse(d, dv); chk("R3 high", d, 8'h9A);
    cur_tag = "R5";
    cyc(1); chk("R5 pending cleared", {7'd0, irq_out}, 8'd0);
    @(negedge clk) lines[5] = 1'b1;
    cyc(2); chk("R5 lower blocked", {7'd0, irq_out}, 8'd0);
    cur_tag = "R10";
    @(negedge clk) lines[1] = 1'b1;
    cyc(1); chk("R10 higher passes", {7'd0, irq_out}, 8'd1);

    // long format, spacing 8, level 1 beats 5
    gap8 = 1; lo = 3'b110;
    pulse(d, dv); chk("R3 opcode again", d, 8'hCD);
    cur_tag = "R4";
    pulse(d, dv); chk("R4 R10 low gap8", d, 8'hC8);
    pulse(d, dv); chk("R3 high again", d, 8'h9A);

    // nested levels 1 and 3 in service; 2 pending
    cur_tag = "R8";
    @(negedge clk) lines[2] = 1'b1;
    cyc(2); chk("R8 blocked by 1", {7'd0, irq_out}, 8'd0);
    end_cmd;
    cyc(1); chk("R8 lowest index released", {7'd0, irq_out}, 8'd1);

    // short format with automatic release, serves level 2
    cur_tag = "R6"; three = 0; autoc = 1; ptr = 5'b10100;
    pulse(d, dv); chk("R6 first undriven", {7'd0, dv}, 8'd0);
    chk("R6 pending gone", {7'd0, irq_out}, 8'd0);
    pulse(d, dv); chk("R6 pointer", d, 8'hA2);
    cur_tag = "R7";
    @(negedge clk) lines[2] = 1'b0;
    @(negedge clk) lines[2] = 1'b1;
    cyc(2); chk("R7 auto released", {7'd0, irq_out}, 8'd1);

    // withdrawn request, short format
    cur_tag = "R9";
    @(negedge clk) lines = '0;
    repeat (3) end_cmd;
    cyc(2);
    @(negedge clk) lines[6] = 1'b1;
    cyc(2); chk("R2 line 6 raise", {7'd0, irq_out}, 8'd1);
    @(negedge clk) lines[6] = 1'b0;
    cyc(1); chk("R2 withdrawn", {7'd0, irq_out}, 8'd0);
    pulse(d, dv); chk("R9 first quiet", {7'd0, dv}, 8'd0);
    pulse(d, dv); chk("R9 fallback pointer", d, 8'hA7);

    // withdrawn request, long format, no auto
    three = 1; autoc = 0;
    pulse(d, dv); chk("R9 opcode", d, 8'hCD);
    pulse(d, dv); chk("R9 fallback low", d, 8'hF8);
    pulse(d, dv); chk("R9 high", d, 8'h9A);
    @(negedge clk) lines[7] = 1'b1;
    cyc(2); chk("R9 nothing in service", {7'd0, irq_out}, 8'd1);

    // short format without auto: level 7 stays in service
    cur_tag = "R7"; three = 0;
    pulse(d, dv); pulse(d, dv); chk("R6 pointer level7", d, 8'hA7);
    @(negedge clk) lines[7] = 1'b0;
    @(negedge clk) lines[7] = 1'b1;
    cyc(2); chk("R7 held without auto", {7'd0, irq_out}, 8'd0);
    end_cmd;
    cyc(1); chk("R8 release level7", {7'd0, irq_out}, 8'd1);

    cyc(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule